// File: doc/BRIEF.md
# Split Page-Size Data TLB

This block is a first-level data-side address translation cache for 48-bit virtual addresses. It keeps translations for three page sizes in three separate set-associative arrays. Each array has its own shape and its own entry layout:

- 4 KB pages: 64 entries, 16 sets of 4 ways.
- 2 MB pages: 32 entries, 8 sets of 4 ways.
- 1 GB pages: 4 entries in a single fully associative set.

A lookup request probes all three arrays in the same cycle. One cycle later the block returns a hit flag, the translated physical address and the page size that matched.

A refill agent installs one translation at a time through the fill port, together with its page size. The fill goes only into the array of that size. It uses the lowest free way of the indexed set, or the pseudo-LRU victim when the set is full. A flush strobe empties all three arrays at once. Instruction-side translation, page walks, permission checks and address-space tagging sit outside this block.

Top module: `split_dtlb`

## Requirements
- R1: After reset no entry is valid, `rspValid` is low, and every lookup reports a miss.
- R2: Each cycle with `lkValid` high produces exactly one response with `rspValid` high on the following cycle. A cycle with `lkValid` low produces `rspValid` low on the following cycle.
- R3: A 4 KB entry uses set index VA[15:12] and tag VA[47:16]. On a hit, `rspPa` is the stored frame PA[45:12] joined with the lookup VA[11:0], and `rspSize` is 0.
- R4: A 2 MB entry uses set index VA[23:21] and tag VA[47:24]. On a hit, `rspPa` is the stored frame PA[45:21] joined with VA[20:0], and `rspSize` is 1.
- R5: A 1 GB entry uses one set with tag VA[47:30]. On a hit, `rspPa` is the stored frame PA[45:30] joined with VA[29:0], and `rspSize` is 2.
- R6: A fill with `fillSize` 0, 1 or 2 writes only the 4 KB, 2 MB or 1 GB array respectively. Each set holds at most 4 translations, and other sets are untouched.
- R7: A fill into a set that has an invalid way takes the lowest-numbered invalid way.
- R8: A fill into a full set replaces the way chosen by a 3-bit pseudo-LRU tree kept per set. Both hits and fills update the tree. When a fill and a hit touch the same set in one cycle, only the fill updates the tree.
- R9: A flush invalidates every entry in one cycle. A lookup in the same cycle reports a miss, and a fill in the same cycle is dropped.
- R10: A lookup sees the array contents from before any fill in the same cycle.
- R11: A miss response has `rspPa` and `rspSize` both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request strobe |
| lkVa | input | 48 | Lookup virtual address |
| fillValid | input | 1 | Fill request strobe |
| fillSize | input | 2 | Fill page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fillVa | input | 48 | Virtual address of the page to install |
| fillPa | input | 46 | Physical address of the page; bits below the page offset are ignored |
| flush | input | 1 | Invalidate all entries |
| rspValid | output | 1 | Response valid, one cycle after `lkValid` |
| rspHit | output | 1 | Lookup hit |
| rspPa | output | 46 | Translated physical address |
| rspSize | output | 2 | Page size of the hit |

## Verification
The bench fills one set past its capacity, after lookups have reordered its recency. A design that ignored hits in its pseudo-LRU tree, or that picked a victim while a free way remained, would evict the wrong translation and miss on a page that should still be present. A lookup and a fill to the same page in one cycle must miss; a design that forwarded the fill would hit a cycle early. A flush combined with a lookup and a fill must leave the arrays empty; a design that let the fill through would keep a stale translation. Long random runs mix all three page sizes, so that a wrong offset width or a swapped size code shows up as a corrupted physical address.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int VA_W = 48;
  localparam int NUM_SIZES = 3;

  typedef enum logic [1:0] {
    PG4K = 2'd0,
    PG2M = 2'd1,
    PG1G = 2'd2
  } pgSizeE;

  // strobes from the control to the page arrays
  typedef struct packed {
    logic                 lookupEn;
    logic                 flushEn;
    logic [NUM_SIZES-1:0] fillEn;
  } tlbStrobeT;
endpackage

// File: rtl/dtlb_page_array.sv
module dtlb_page_array #(
  parameter int VaW  = 48,
  parameter int PaW  = 46,
  parameter int Sets = 16,
  parameter int Ways = 4,
  parameter int OffW = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           lookupEn,
  input  logic           flushEn,
  input  logic           fillEn,
  input  logic [VaW-1:0] lkVa,
  input  logic [VaW-1:0] fillVa,
  input  logic [PaW-1:0] fillPa,
  output logic           hit,
  output logic [PaW-1:0] hitPa
);
  localparam int SetBits = (Sets > 1) ? $clog2(Sets) : 0;
  localparam int IdxW    = (SetBits > 0) ? SetBits : 1;
  localparam int TagLo   = OffW + SetBits;
  localparam int TagW    = VaW - TagLo;
  localparam int FrmW    = PaW - OffW;
  localparam int LvlW    = $clog2(Ways);
  localparam int WayW    = (LvlW > 0) ? LvlW : 1;
  localparam int TreeW   = Ways - 1;

  logic [Ways-1:0]  vld    [Sets];
  logic [TagW-1:0]  tagMem [Sets][Ways];
  logic [FrmW-1:0]  frmMem [Sets][Ways];
  logic [TreeW-1:0] tree   [Sets];

  logic [IdxW-1:0] lkIdx, fillIdx;
  logic [TagW-1:0] lkTag, fillTag;
  logic [Ways-1:0] wayHit;
  logic [WayW-1:0] hitWay, fillWay;
  logic            anyVld;

  assign lkTag   = lkVa[VaW-1:TagLo];
  assign fillTag = fillVa[VaW-1:TagLo];

  if (SetBits > 0) begin : g_idx
    assign lkIdx   = lkVa[TagLo-1:OffW];
    assign fillIdx = fillVa[TagLo-1:OffW];
  end else begin : g_noidx
    assign lkIdx   = '0;
    assign fillIdx = '0;
  end

  // walk the tree towards the least recently used leaf
  function automatic logic [WayW-1:0] plruVictim(input logic [TreeW-1:0] t);
    int node;
    logic [WayW-1:0] way;
    node = 0;
    way  = '0;
    for (int l = 0; l < LvlW; l++) begin
      way  = WayW'({way, t[node]});
      node = 2 * node + 1 + int'(t[node]);
    end
    return way;
  endfunction

  // point every node on the path away from the used way
  function automatic logic [TreeW-1:0] plruTouch(input logic [TreeW-1:0] t,
                                                 input logic [WayW-1:0] way);
    int node;
    logic b;
    node = 0;
    for (int l = 0; l < LvlW; l++) begin
      b       = way[LvlW-1-l];
      t[node] = ~b;
      node    = 2 * node + 1 + int'(b);
    end
    return t;
  endfunction

  always_comb begin
    wayHit = '0;
    hitWay = '0;
    for (int w = 0; w < Ways; w++)
      if (vld[lkIdx][w] && tagMem[lkIdx][w] == lkTag) wayHit[w] = 1'b1;
    for (int w = Ways - 1; w >= 0; w--)
      if (wayHit[w]) hitWay = WayW'(w);
  end

  assign hit   = lookupEn && (|wayHit);
  assign hitPa = hit ? {frmMem[lkIdx][hitWay], lkVa[OffW-1:0]} : '0;

  always_comb begin
    fillWay = plruVictim(tree[fillIdx]);
    for (int w = Ways - 1; w >= 0; w--)
      if (!vld[fillIdx][w]) fillWay = WayW'(w);
  end

  always_comb begin
    anyVld = 1'b0;
    for (int s = 0; s < Sets; s++) anyVld = anyVld | (|vld[s]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < Sets; s++) begin
        vld[s]  <= '0;
        tree[s] <= '0;
      end
    end else if (flushEn) begin
      for (int s = 0; s < Sets; s++) vld[s] <= '0;
    end else begin
      if (fillEn) begin
        vld[fillIdx][fillWay]    <= 1'b1;
        tagMem[fillIdx][fillWay] <= fillTag;
        frmMem[fillIdx][fillWay] <= fillPa[PaW-1:OffW];
        tree[fillIdx]            <= plruTouch(tree[fillIdx], fillWay);
      end
      if (hit && !(fillEn && fillIdx == lkIdx))
        tree[lkIdx] <= plruTouch(tree[lkIdx], hitWay);
    end
  end

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |=> !anyVld);

  // R7
  fill_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flushEn && !(&vld[fillIdx])) |=>
      ($countones(vld[$past(fillIdx)]) == $countones($past(vld[fillIdx])) + 1));

  // R6
  way_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wayHit));
endmodule

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
#(
  parameter int PaW = 46
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lkValid,
  input  logic                           fillValid,
  input  logic [1:0]                     fillSize,
  input  logic                           flush,
  input  logic [NUM_SIZES-1:0]           hitVec,
  input  logic [NUM_SIZES-1:0][PaW-1:0]  hitPaVec,
  output tlbStrobeT                      strobes,
  output logic                           rspValid,
  output logic                           rspHit,
  output logic [PaW-1:0]                 rspPa,
  output logic [1:0]                     rspSize
);
  always_comb begin
    strobes.lookupEn = lkValid && !flush;
    strobes.flushEn  = flush;
    for (int i = 0; i < NUM_SIZES; i++)
      strobes.fillEn[i] = fillValid && !flush && (fillSize == 2'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPa    <= '0;
      rspSize  <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= |hitVec;
      rspPa    <= '0;
      rspSize  <= '0;
      // the largest page size takes priority
      if (hitVec[PG1G]) begin
        rspPa   <= hitPaVec[PG1G];
        rspSize <= PG1G;
      end else if (hitVec[PG2M]) begin
        rspPa   <= hitPaVec[PG2M];
        rspSize <= PG2M;
      end else if (hitVec[PG4K]) begin
        rspPa   <= hitPaVec[PG4K];
        rspSize <= PG4K;
      end
    end
  end

  // R2
  rsp_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);

  // R9
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !rspHit);

  // R3
  one_array_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspPa == '0 && rspSize == 2'd0));
endmodule

// File: rtl/split_dtlb.sv
module split_dtlb
  import dtlb_pkg::*;
#(
  parameter int PaW    = 46,
  parameter int Sets4k = 16,
  parameter int Ways4k = 4,
  parameter int Sets2m = 8,
  parameter int Ways2m = 4,
  parameter int Sets1g = 1,
  parameter int Ways1g = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lkValid,
  input  logic [VA_W-1:0] lkVa,
  input  logic            fillValid,
  input  logic [1:0]      fillSize,
  input  logic [VA_W-1:0] fillVa,
  input  logic [PaW-1:0]  fillPa,
  input  logic            flush,
  output logic            rspValid,
  output logic            rspHit,
  output logic [PaW-1:0]  rspPa,
  output logic [1:0]      rspSize
);
  tlbStrobeT                      strobes;
  logic [NUM_SIZES-1:0]           hitVec;
  logic [NUM_SIZES-1:0][PaW-1:0]  hitPaVec;

  dtlb_ctrl #(.PaW(PaW)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lkValid  (lkValid),
    .fillValid(fillValid),
    .fillSize (fillSize),
    .flush    (flush),
    .hitVec   (hitVec),
    .hitPaVec (hitPaVec),
    .strobes  (strobes),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspPa    (rspPa),
    .rspSize  (rspSize)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_arr
    localparam int SetsG = (g == 0) ? Sets4k : (g == 1) ? Sets2m : Sets1g;
    localparam int WaysG = (g == 0) ? Ways4k : (g == 1) ? Ways2m : Ways1g;
    localparam int OffG  = (g == 0) ? 12 : (g == 1) ? 21 : 30;

    dtlb_page_array #(
      .VaW (VA_W),
      .PaW (PaW),
      .Sets(SetsG),
      .Ways(WaysG),
      .OffW(OffG)
    ) i_arr (
      .clk     (clk),
      .rstN    (rstN),
      .lookupEn(strobes.lookupEn),
      .flushEn (strobes.flushEn),
      .fillEn  (strobes.fillEn[g]),
      .lkVa    (lkVa),
      .fillVa  (fillVa),
      .fillPa  (fillPa),
      .hit     (hitVec[g]),
      .hitPa   (hitPaVec[g])
    );
  end
endmodule

// File: tb/test_split_dtlb.sv
`timescale 1ns/1ps
module test_split_dtlb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        lkValid;
  logic [47:0] lkVa;
  logic        fillValid;
  logic [1:0]  fillSize;
  logic [47:0] fillVa;
  logic [45:0] fillPa;
  logic        flush;
  logic        rspValid, rspHit;
  logic [45:0] rspPa;
  logic [1:0]  rspSize;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  split_dtlb i_split_dtlb (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa),
    .fillValid(fillValid), .fillSize(fillSize), .fillVa(fillVa), .fillPa(fillPa),
    .flush(flush), .rspValid(rspValid), .rspHit(rspHit), .rspPa(rspPa), .rspSize(rspSize)
  );

  // behavioural reference state
  bit                mV [3][16][4];
  longint unsigned   mT [3][16][4];
  longint unsigned   mF [3][16][4];
  bit                mB [3][16][3];

  function automatic int offOf(int s);  return (s == 0) ? 12 : (s == 1) ? 21 : 30; endfunction
  function automatic int setsOf(int s); return (s == 0) ? 16 : (s == 1) ? 8 : 1;   endfunction
  function automatic int sbOf(int s);   return (s == 0) ? 4 : (s == 1) ? 3 : 0;    endfunction

  function automatic int idxOf(int s, logic [47:0] va);
    return int'((64'(va) >> offOf(s)) % 64'(setsOf(s)));
  endfunction
  function automatic longint unsigned tagOf(int s, logic [47:0] va);
    return 64'(va) >> (offOf(s) + sbOf(s));
  endfunction

  function automatic int findWay(int s, logic [47:0] va);
    int i = idxOf(s, va);
    for (int w = 0; w < 4; w++)
      if (mV[s][i][w] && mT[s][i][w] == tagOf(s, va)) return w;
    return -1;
  endfunction

  function automatic void touch(int s, int i, int w);
    mB[s][i][0] = (w < 2);
    if (w < 2) mB[s][i][1] = (w == 0);
    else       mB[s][i][2] = (w == 2);
  endfunction

  function automatic int victim(int s, int i);
    if (!mB[s][i][0]) return mB[s][i][1] ? 1 : 0;
    return mB[s][i][2] ? 3 : 2;
  endfunction

  task automatic cyc(bit lk, logic [47:0] va, bit fl, int fsz, logic [47:0] fva,
                     logic [45:0] fpa, bit fsh, string rq);
    bit eh = 0;
    logic [45:0] epa = '0;
    int esz = 0, es = -1, ei = 0, ew = 0;
    lkValid = lk; lkVa = va; fillValid = fl; fillSize = 2'(fsz);
    fillVa = fva; fillPa = fpa; flush = fsh;
    if (lk && !fsh) begin
      for (int s = 2; s >= 0; s--) begin
        int w = findWay(s, va);
        if (w >= 0 && es < 0) begin
          es = s; ei = idxOf(s, va); ew = w; eh = 1; esz = s;
          epa = 46'((mF[s][ei][w] << offOf(s)) |
                    (64'(va) & ((64'd1 << offOf(s)) - 1)));
        end
      end
    end
    if (fsh) begin
      for (int s = 0; s < 3; s++)
        for (int i = 0; i < 16; i++)
          for (int w = 0; w < 4; w++) mV[s][i][w] = 0;
    end else begin
      bit doFill = fl && fsz < 3;
      int fi = doFill ? idxOf(fsz, fva) : 0;
      if (eh && !(doFill && fsz == es && fi == ei)) touch(es, ei, ew);
      if (doFill) begin
        int fw = -1;
        for (int w = 3; w >= 0; w--) if (!mV[fsz][fi][w]) fw = w;
        if (fw < 0) fw = victim(fsz, fi);
        mV[fsz][fi][fw] = 1;
        mT[fsz][fi][fw] = tagOf(fsz, fva);
        mF[fsz][fi][fw] = 64'(fpa) >> offOf(fsz);
        touch(fsz, fi, fw);
      end
    end
    @(posedge clk);
    #1;
    checks++;
    if (rspValid !== lk ||
        (lk && (rspHit !== eh || rspPa !== epa || rspSize !== 2'(esz)))) begin
      fails++;
      $display("FAIL %s: va=%h got v=%0b h=%0b pa=%h sz=%0d exp v=%0b h=%0b pa=%h sz=%0d",
               rq, va, rspValid, rspHit, rspPa, rspSize, lk, eh, epa, esz);
    end
  endtask

  task automatic look(logic [47:0] va, string rq);
    cyc(1, va, 0, 0, '0, '0, 0, rq);
  endtask
  task automatic put(int sz, logic [47:0] va, logic [45:0] pa, string rq);
    cyc(0, '0, 1, sz, va, pa, 0, rq);
  endtask

  function automatic logic [47:0] mkVa(int s, int t, int set, longint unsigned off);
    case (s)
      0: return 48'h0100_0000_0000 | 48'(t << 16) | 48'(set << 12) | 48'(off & 64'hfff);
      1: return 48'h0200_0000_0000 | 48'(64'(t) << 24) | 48'(set << 21) | 48'(off & 64'h1f_ffff);
      default: return 48'h0300_0000_0000 | 48'(64'(t) << 30) | 48'(off & 64'h3fff_ffff);
    endcase
  endfunction

  initial begin
    #(4ns * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    rstN = 0; lkValid = 0; lkVa = '0; fillValid = 0; fillSize = '0;
    fillVa = '0; fillPa = '0; flush = 0;
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 16; i++)
        for (int w = 0; w < 4; w++) begin
          mV[s][i][w] = 0;
          if (w < 3) mB[s][i][w] = 0;
        end
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset got v=%0b h=%0b exp 0 0", rspValid, rspHit);
    end
    rstN = 1;

    look(mkVa(0, 0, 3, 'h10), "R1");
    look(mkVa(2, 0, 0, 'h10), "R1");
    cyc(0, '0, 0, 0, '0, '0, 0, "R2");
    // lookup and fill of the same page in one cycle
    cyc(1, mkVa(0, 0, 3, 'h44), 1, 0, mkVa(0, 0, 3, 0), 46'h12_3456_7000, 0, "R10");
    look(mkVa(0, 0, 3, 'h123), "R3");
    look(mkVa(0, 0, 4, 'h123), "R3");
    put(1, mkVa(1, 1, 2, 0), 46'h2a_bcd0_0000, "R4");
    look(mkVa(1, 1, 2, 'h1_2345), "R4");
    look(mkVa(1, 1, 3, 'h1_2345), "R4");
    put(2, mkVa(2, 1, 0, 0), 46'h3_c000_0000, "R5");
    look(mkVa(2, 1, 0, 'h1234_5678), "R5");
    put(3, mkVa(0, 7, 3, 0), 46'h1111_1000, "R6");
    look(mkVa(0, 7, 3, 0), "R6");
    // fill set 3 of the 4 KB array past capacity
    for (int t = 1; t < 4; t++) put(0, mkVa(0, t, 3, 0), 46'(64'h100000 * t), "R7");
    for (int t = 0; t < 4; t++) look(mkVa(0, t, 3, 'h8), "R7");
    look(mkVa(0, 1, 3, 0), "R8");
    look(mkVa(0, 2, 3, 0), "R8");
    put(0, mkVa(0, 5, 3, 0), 46'h55_5000, "R8");
    for (int t = 0; t < 6; t++) look(mkVa(0, t, 3, 'h3), "R8");
    put(0, mkVa(0, 6, 3, 0), 46'h66_6000, "R8");
    for (int t = 0; t < 7; t++) look(mkVa(0, t, 3, 'h3), "R8");
    for (int t = 2; t < 7; t++) put(2, mkVa(2, t, 0, 0), 46'(64'h4000_0000 * t), "R6");
    for (int t = 1; t < 7; t++) look(mkVa(2, t, 0, 'h77), "R6");
    // flush together with a lookup and a fill
    cyc(1, mkVa(1, 1, 2, 5), 1, 1, mkVa(1, 4, 1, 0), 46'h7_0000_0000, 1, "R9");
    look(mkVa(1, 4, 1, 0), "R9");
    look(mkVa(0, 0, 3, 0), "R9");
    look(mkVa(2, 1, 0, 0), "R9");

    for (int n = 0; n < 4000; n++) begin
      int s  = int'($urandom % 3);
      int fs = int'($urandom % 3);
      logic [47:0] va  = mkVa(s, int'($urandom % 6), int'($urandom % 4), {$urandom, $urandom});
      logic [47:0] fva = mkVa(fs, int'($urandom % 6), int'($urandom % 4), 0);
      logic [63:0] r64 = {$urandom, $urandom};
      bit lk = ($urandom % 4) != 0;
      bit fl = (($urandom % 3) == 0) && (findWay(fs, fva) < 0);
      bit fsh = ($urandom % 200) == 0;
      cyc(lk, va, fl, fs, fva, r64[45:0], fsh, "R8");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule